// File: doc/BRIEF.md
# Cached DRAM Control Strobe Decoder

This block is the control front end of a DRAM that keeps one row in an SRAM cache. It samples a set of active-low strobes (row enable, refresh, column latch, write enable, output enable, chip select) along with a write/read level and a multiplexed address. Every falling edge of row enable is sorted into a read, a write or a refresh. The block reports that operation as a one-cycle pulse and captures the row address used by the cycle.

The block also keeps a free-running refresh row counter and remembers the last row that was read. It uses that record in two ways: it raises a hit flag when a read repeats the cached row, and it drops a refresh whose row is the cached row. A column latch passes the address through while open and holds it while closed. Two derived levels, the write-data strobe and the output-drive enable, are decoded from the strobes and from the kind of cycle in progress. A mode input selects reduced-pin wiring, in which the column latch strobe also serves as the refresh strobe and the write enable.

Top module: `cdram_strobe_dec`

## Requirements
- R1: A row-enable fall with chip select low and the effective refresh strobe high is a write if wr_rd is 1 and a read if wr_rd is 0. In the cycle after the sampling edge, wr_pulse or rd_pulse is high for exactly one cycle, and row_q holds the address sampled at that edge.
- R2: A row-enable fall with the effective refresh strobe low is a refresh. Its row is the internal counter, which row_q takes. The counter is ROW_W bits wide, starts at 0, advances by one after every refresh cycle whether that cycle is performed or skipped, and wraps from all-ones to 0.
- R3: When chip select is high, a read or write fall produces no pulse and leaves row_q unchanged. A refresh fall is still serviced.
- R4: A refresh whose counter row equals the last-read row, after at least one read, produces no ref_pulse. Any other refresh produces ref_pulse for one cycle.
- R5: col_q equals addr[COL_W-1:0] while cal_n is high. While cal_n is low, col_q holds the value it had at the last clock edge at which cal_n was high.
- R6: During a write cycle (from the write fall until row enable rises), wdata_stb is high exactly when cal_n and the effective write enable are both low and chip select is low.
- R7: dq_oe is high only when the most recent read or write fall was a read, oe_n is low and chip select is low. It is low after a write.
- R8: At every read, cache_hit is set to 1 if the read row equals the last-read row, and to 0 otherwise. The read row then becomes the last-read row.
- R9: With pin_merge high, cal_n acts as the refresh and write-enable strobe. Holding cal_n low at a row-enable fall gives a refresh. Taking cal_n low during a write raises wdata_stb.
- R10: After reset, all pulses, row_q, cache_hit, dq_oe and wdata_stb are 0, and no last-read row is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset |
| re_n | input | 1 | Row enable, active low |
| ref_n | input | 1 | Refresh request, active low |
| wr_rd | input | 1 | 1 = write, 0 = read |
| cal_n | input | 1 | Column latch strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| cs_n | input | 1 | Chip select, active low |
| pin_merge | input | 1 | 1 = cal_n also serves as refresh and write enable |
| addr | input | ROW_W | Multiplexed row/column address |
| rd_pulse | output | 1 | Read started |
| wr_pulse | output | 1 | Write started |
| ref_pulse | output | 1 | Refresh performed |
| row_q | output | ROW_W | Row of the latest accepted cycle |
| col_q | output | COL_W | Column latch output |
| wdata_stb | output | 1 | Write data capture strobe |
| dq_oe | output | 1 | Data output drive enable |
| cache_hit | output | 1 | Last read hit the cached row |

## Verification
The bench builds the block with ROW_W = 6 and COL_W = 4. At this width the refresh counter passes from 63 back to 0 within a few hundred cycles, so the wrap and the skip on a counter match can both be checked directly. The narrow column also leaves the upper address bits free, which shows that only the low bits reach the column latch.

// File: rtl/cdram_strobe_dec.sv
module cdram_strobe_dec #(
  parameter int ROW_W = 11,
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             re_n,
  input  logic             ref_n,
  input  logic             wr_rd,
  input  logic             cal_n,
  input  logic             we_n,
  input  logic             oe_n,
  input  logic             cs_n,
  input  logic             pin_merge,
  input  logic [ROW_W-1:0] addr,
  output logic             rd_pulse,
  output logic             wr_pulse,
  output logic             ref_pulse,
  output logic [ROW_W-1:0] row_q,
  output logic [COL_W-1:0] col_q,
  output logic             wdata_stb,
  output logic             dq_oe,
  output logic             cache_hit
);
  localparam logic [ROW_W-1:0] ONE = 1;

  logic             re_d, lrr_v, wr_act, rd_act;
  logic [ROW_W-1:0] rcnt, lrr;
  logic [COL_W-1:0] col_hold;

  wire ref_in = pin_merge ? cal_n : ref_n;
  wire we_in  = pin_merge ? cal_n : we_n;
  wire fall   = re_d & ~re_n;
  wire is_ref = fall & ~ref_in;
  wire is_acc = fall & ref_in & ~cs_n;
  wire skip   = lrr_v && (rcnt == lrr);

  assign col_q     = cal_n ? addr[COL_W-1:0] : col_hold;
  assign wdata_stb = wr_act & ~cal_n & ~we_in & ~cs_n;
  assign dq_oe     = rd_act & ~oe_n & ~cs_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      re_d      <= 1'b1;
      rd_pulse  <= 1'b0;
      wr_pulse  <= 1'b0;
      ref_pulse <= 1'b0;
      row_q     <= '0;
      rcnt      <= '0;
      lrr       <= '0;
      lrr_v     <= 1'b0;
      wr_act    <= 1'b0;
      rd_act    <= 1'b0;
      cache_hit <= 1'b0;
      col_hold  <= '0;
    end else begin
      re_d      <= re_n;
      rd_pulse  <= 1'b0;
      wr_pulse  <= 1'b0;
      ref_pulse <= 1'b0;
      if (cal_n) col_hold <= addr[COL_W-1:0];
      if (re_n) wr_act <= 1'b0;
      if (is_ref) begin
        row_q     <= rcnt;
        rcnt      <= rcnt + ONE;
        ref_pulse <= !skip;
      end else if (is_acc) begin
        row_q <= addr;
        if (wr_rd) begin
          wr_pulse <= 1'b1;
          wr_act   <= 1'b1;
          rd_act   <= 1'b0;
        end else begin
          rd_pulse  <= 1'b1;
          rd_act    <= 1'b1;
          cache_hit <= lrr_v && (addr == lrr);
          lrr       <= addr;
          lrr_v     <= 1'b1;
        end
      end
    end
  end

  // R1
  one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_pulse, wr_pulse, ref_pulse}));

  // R3
  standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && cs_n && ref_in) |=> !(rd_pulse || wr_pulse));

  // R2
  ref_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ref_pulse |-> (rcnt == row_q + ONE));

  // R6
  wstb_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_stb |-> !dq_oe);

  // R8
  hit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cache_hit) |-> rd_pulse);
endmodule

// File: tb/sim_cdram_strobe_dec.sv
`timescale 1ns/1ps
module sim_cdram_strobe_dec;
  localparam int RW = 6;
  localparam int CW = 4;

  logic clk = 0, rst_n = 0;
  logic re_n = 1, ref_n = 1, wr_rd = 0, cal_n = 1, we_n = 1, oe_n = 1, cs_n = 0, pin_merge = 0;
  logic [RW-1:0] addr = '0;
  logic rd_pulse, wr_pulse, ref_pulse, wdata_stb, dq_oe, cache_hit;
  logic [RW-1:0] row_q;
  logic [CW-1:0] col_q;

  cdram_strobe_dec #(.ROW_W(RW), .COL_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .re_n(re_n), .ref_n(ref_n), .wr_rd(wr_rd),
    .cal_n(cal_n), .we_n(we_n), .oe_n(oe_n), .cs_n(cs_n), .pin_merge(pin_merge),
    .addr(addr), .rd_pulse(rd_pulse), .wr_pulse(wr_pulse), .ref_pulse(ref_pulse),
    .row_q(row_q), .col_q(col_q), .wdata_stb(wdata_stb), .dq_oe(dq_oe),
    .cache_hit(cache_hit));

  always #2.5 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [RW-1:0] ecnt = '0, elrr = '0;
  bit elrr_v = 0;
  logic p_rd, p_wr, p_ref;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fall(input logic w, input logic rf, input logic [RW-1:0] a);
    @(negedge clk);
    wr_rd = w; ref_n = rf; addr = a; re_n = 0;
    @(posedge clk); #1;
    p_rd = rd_pulse; p_wr = wr_pulse; p_ref = ref_pulse;
  endtask

  task automatic rel();
    @(negedge clk);
    re_n = 1; ref_n = 1;
    @(posedge clk); #1;
  endtask

  task automatic do_read(input logic [RW-1:0] a);
    bit eh;
    eh = elrr_v && (elrr == a);
    fall(0, 1, a);
    chk(p_rd === 1 && p_wr === 0, "R1 read pulse", p_rd, 1);
    chk(row_q === a, "R1 read row", row_q, a);
    chk(cache_hit === eh, "R8 hit flag", cache_hit, eh);
    elrr = a; elrr_v = 1;
    rel();
    chk(rd_pulse === 0, "R1 pulse one cycle", rd_pulse, 0);
  endtask

  task automatic do_ref();
    bit er;
    er = !(elrr_v && elrr == ecnt);
    fall(0, 0, '0);
    chk(p_ref === er, er ? "R2 refresh performed" : "R4 refresh skipped", p_ref, er);
    chk(row_q === ecnt, "R2 counter row", row_q, ecnt);
    ecnt = ecnt + 1'b1;
    rel();
  endtask

  task automatic t_reset();
    chk(rd_pulse === 0 && wr_pulse === 0 && ref_pulse === 0, "R10 pulses", rd_pulse, 0);
    chk(row_q === 0, "R10 row", row_q, 0);
    chk(cache_hit === 0 && dq_oe === 0 && wdata_stb === 0, "R10 flags", cache_hit, 0);
  endtask

  task automatic t_read();
    do_read(6'd5);
    do_read(6'd5);
    do_read(6'd9);
  endtask

  task automatic t_write();
    fall(1, 1, 6'd12);
    chk(p_wr === 1 && p_rd === 0, "R1 write pulse", p_wr, 1);
    chk(row_q === 12, "R1 write row", row_q, 12);
    chk(wdata_stb === 0, "R6 idle strobe", wdata_stb, 0);
    @(negedge clk); cal_n = 0; we_n = 0; #1;
    chk(wdata_stb === 1, "R6 strobe both low", wdata_stb, 1);
    @(negedge clk); we_n = 1; #1;
    chk(wdata_stb === 0, "R6 strobe we high", wdata_stb, 0);
    @(negedge clk); cal_n = 1;
    rel();
  endtask

  task automatic t_oe();
    do_read(6'd20);
    @(negedge clk); oe_n = 0; #1;
    chk(dq_oe === 1, "R7 drive on read", dq_oe, 1);
    @(negedge clk); oe_n = 1;
    fall(1, 1, 6'd21);
    rel();
    @(negedge clk); oe_n = 0; #1;
    chk(dq_oe === 0, "R7 no drive after write", dq_oe, 0);
    @(negedge clk); oe_n = 1;
  endtask

  task automatic t_standby();
    logic [RW-1:0] prev;
    prev = row_q;
    @(negedge clk); cs_n = 1;
    fall(0, 1, 6'd33);
    chk(p_rd === 0 && p_wr === 0, "R3 standby ignored", p_rd, 0);
    chk(row_q === prev, "R3 row unchanged", row_q, prev);
    rel();
    do_ref();
    @(negedge clk); cs_n = 0;
  endtask

  task automatic t_skip();
    do_read(ecnt);
    do_ref();
    do_ref();
  endtask

  task automatic t_wrap();
    bit seen;
    seen = 0;
    for (int i = 0; i < 70; i++) begin
      if (ecnt == '1) seen = 1;
      do_ref();
      if (seen && i < 69 && ecnt == 1) chk(row_q === 0, "R2 wrap to zero", row_q, 0);
    end
    chk(seen, "R2 wrap reached", seen, 1);
  endtask

  task automatic t_col();
    @(negedge clk); cal_n = 1; addr = 6'h2A; #1;
    chk(col_q === 4'hA, "R5 transparent", col_q, 4'hA);
    @(negedge clk); cal_n = 0; addr = 6'h17; #1;
    chk(col_q === 4'hA, "R5 hold", col_q, 4'hA);
    @(negedge clk); #1;
    chk(col_q === 4'hA, "R5 hold later", col_q, 4'hA);
    @(negedge clk); cal_n = 1; #1;
    chk(col_q === 4'h7, "R5 reopen", col_q, 4'h7);
  endtask

  task automatic t_merge();
    bit er;
    @(negedge clk); pin_merge = 1; cal_n = 0;
    er = !(elrr_v && elrr == ecnt);
    fall(0, 1, 6'd3);
    chk(p_ref === er && p_rd === 0, "R9 combined refresh", p_ref, er);
    chk(row_q === ecnt, "R9 refresh row", row_q, ecnt);
    ecnt = ecnt + 1'b1;
    rel();
    @(negedge clk); cal_n = 1;
    fall(1, 1, 6'd44);
    chk(p_wr === 1, "R9 write start", p_wr, 1);
    @(negedge clk); cal_n = 0; #1;
    chk(wdata_stb === 1, "R9 combined strobe", wdata_stb, 1);
    @(negedge clk); cal_n = 1;
    rel();
    @(negedge clk); pin_merge = 0;
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    t_reset();
    t_read();
    t_write();
    t_oe();
    t_standby();
    t_skip();
    t_wrap();
    t_col();
    t_merge();
    finish_up();
  end
endmodule